// File: doc/BRIEF.md
# Halfword and Doubleword Copy Unit

This block rearranges lanes of 128-bit register values. From two 128-bit source operands it builds one destination value in one of three fixed patterns: a halfword broadcast that replicates the lowest halfword of each 64-bit half across that half, a copy-lower pattern that places the lower doublewords of both sources side by side, and a copy-upper pattern that does the same with the upper doublewords.

The caller passes the register index of each source and of the destination along with the operands. A source index of 0 names the hard-wired zero register, so its operand reads as all zeros whatever value sits on the data port. A destination index of 0 turns the operation into a no-op, and no write is requested. Results come out of one pipeline register, together with a valid flag, a write-enable and the destination index. A new operation can be accepted on every cycle.

The result depends only on the current operands, the indices and the mode. The unit keeps no history between operations.

Top module: `lane_copy_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears out_valid, out_wen, out_dst and out_data to zero.
- R2: out_valid equals in_valid one clock edge later, and out_dst carries the dst_idx that was accepted with it.
- R3: With op_sel = 2'b00 (halfword broadcast), bits [15:0] of src_b fill all four halfwords of out_data[63:0], and bits [79:64] of src_b fill all four halfwords of out_data[127:64].
- R4: In broadcast mode with b_idx = 0, the whole 128-bit result is zero while out_wen is still asserted.
- R5: With op_sel = 2'b01 (copy lower), out_data[127:64] = src_a[63:0] and out_data[63:0] = src_b[63:0].
- R6: With op_sel = 2'b10 (copy upper), out_data[63:0] = src_a[127:64] and out_data[127:64] = src_b[127:64].
- R7: In the copy modes, a_idx = 0 makes the half fed by src_a zero, and b_idx = 0 makes the half fed by src_b zero. The other half is unaffected.
- R8: dst_idx = 0 gives out_wen = 0 and out_data = 0 for that operation, in every mode.
- R9: op_sel = 2'b11 is reserved and gives out_wen = 0 and out_data = 0.
- R10: Operations issued on consecutive cycles each give their own result on the cycle after issue, with no influence from the one before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 2 | Mode: 00 broadcast, 01 copy lower, 10 copy upper, 11 reserved |
| src_a | input | 128 | First source operand |
| src_b | input | 128 | Second source operand (broadcast source) |
| a_idx | input | 5 | Register index of src_a; 0 forces zeros |
| b_idx | input | 5 | Register index of src_b; 0 forces zeros |
| dst_idx | input | 5 | Destination register index; 0 suppresses the write |
| out_valid | output | 1 | Registered result is present |
| out_wen | output | 1 | Destination write requested |
| out_dst | output | 5 | Destination index of the registered result |
| out_data | output | 128 | Registered result |

## Verification
An operation applied before a rising edge has its result on every output one edge later. The bench drives inputs on the falling edge and samples one time unit after the following rising edge, so each check lands inside the single cycle in which that result is held. For the back-to-back case, the next operation goes onto the inputs right after sampling, and its result is checked after the next edge. One more sample after in_valid drops confirms that out_valid goes low on that edge too.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

   typedef enum logic [1:0] {
      LCU_HBCAST = 2'b00,
      LCU_CPYLO  = 2'b01,
      LCU_CPYHI  = 2'b10,
      LCU_RSVD   = 2'b11
   } lcu_op_e;

   function automatic logic lcu_op_legal(input logic [1:0] op);
      return (op != LCU_RSVD);
   endfunction

endpackage

// File: rtl/lcu_operand_gate.sv
// Forces an operand to zero when its register index names the zero register.
module lcu_operand_gate #(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] gated
);
   logic is_zero_reg;

   always_comb begin
      is_zero_reg = (idx == '0);
      gated       = is_zero_reg ? '0 : raw;
   end
endmodule

// File: rtl/lcu_hbcast.sv
// Replicates the lowest halfword of one half across every halfword of that half.
module lcu_hbcast #(
   parameter int HALF_W = 64,
   parameter int HW_W   = 16
) (
   input  logic [HALF_W-1:0] half_in,
   output logic [HALF_W-1:0] half_out
);
   localparam int N_HW = HALF_W / HW_W;

   logic [HW_W-1:0] seed;
   assign seed = half_in[HW_W-1:0];

   for (genvar g = 0; g < N_HW; g++) begin : g_rep
      assign half_out[g*HW_W +: HW_W] = seed;
   end
endmodule

// File: rtl/lcu_route.sv
// Chooses each destination half from the candidates; the choice depends only on the mode.
module lcu_route
   import lcu_pkg::*;
#(
   parameter int HALF_W = 64
) (
   input  logic [1:0]        op,
   input  logic [HALF_W-1:0] a_lo,
   input  logic [HALF_W-1:0] a_hi,
   input  logic [HALF_W-1:0] b_lo,
   input  logic [HALF_W-1:0] b_hi,
   input  logic [HALF_W-1:0] bc_lo,
   input  logic [HALF_W-1:0] bc_hi,
   output logic [HALF_W-1:0] res_lo,
   output logic [HALF_W-1:0] res_hi,
   output logic              op_ok
);
   lcu_op_e mode;

   always_comb begin
      mode  = lcu_op_e'(op);
      op_ok = lcu_op_legal(op);
      unique case (mode)
         LCU_HBCAST: begin
            res_lo = bc_lo;
            res_hi = bc_hi;
         end
         LCU_CPYLO: begin
            res_lo = b_lo;
            res_hi = a_lo;
         end
         LCU_CPYHI: begin
            res_lo = a_hi;
            res_hi = b_hi;
         end
         default: begin
            res_lo = '0;
            res_hi = '0;
         end
      endcase
   end
endmodule

// File: rtl/lane_copy_unit.sv
module lane_copy_unit
   import lcu_pkg::*;
#(
   parameter int HALF_W = 64,
   parameter int HW_W   = 16,
   parameter int IDX_W  = 5
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [1:0]            op_sel,
   input  logic [2*HALF_W-1:0]   src_a,
   input  logic [2*HALF_W-1:0]   src_b,
   input  logic [IDX_W-1:0]      a_idx,
   input  logic [IDX_W-1:0]      b_idx,
   input  logic [IDX_W-1:0]      dst_idx,
   output logic                  out_valid,
   output logic                  out_wen,
   output logic [IDX_W-1:0]      out_dst,
   output logic [2*HALF_W-1:0]   out_data
);
   localparam int REG_W = 2 * HALF_W;

   if (HW_W <= 0 || HALF_W % HW_W != 0) begin : g_bad_hw
      $error("lane_copy_unit: HALF_W must be a whole multiple of HW_W");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("lane_copy_unit: IDX_W must be at least 1");
   end

   logic [REG_W-1:0]  a_g, b_g;
   logic [HALF_W-1:0] bc_lo, bc_hi, res_lo, res_hi;
   logic              op_ok, do_write;

   lcu_operand_gate #(.DATA_W(REG_W), .IDX_W(IDX_W)) u_gate_a (
      .idx(a_idx), .raw(src_a), .gated(a_g)
   );
   lcu_operand_gate #(.DATA_W(REG_W), .IDX_W(IDX_W)) u_gate_b (
      .idx(b_idx), .raw(src_b), .gated(b_g)
   );

   lcu_hbcast #(.HALF_W(HALF_W), .HW_W(HW_W)) u_bc_lo (
      .half_in(b_g[HALF_W-1:0]), .half_out(bc_lo)
   );
   lcu_hbcast #(.HALF_W(HALF_W), .HW_W(HW_W)) u_bc_hi (
      .half_in(b_g[REG_W-1:HALF_W]), .half_out(bc_hi)
   );

   lcu_route #(.HALF_W(HALF_W)) u_route (
      .op    (op_sel),
      .a_lo  (a_g[HALF_W-1:0]),
      .a_hi  (a_g[REG_W-1:HALF_W]),
      .b_lo  (b_g[HALF_W-1:0]),
      .b_hi  (b_g[REG_W-1:HALF_W]),
      .bc_lo (bc_lo),
      .bc_hi (bc_hi),
      .res_lo(res_lo),
      .res_hi(res_hi),
      .op_ok (op_ok)
   );

   assign do_write = in_valid && op_ok && (dst_idx != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_wen   <= 1'b0;
         out_dst   <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_wen   <= do_write;
         out_dst   <= in_valid ? dst_idx : '0;
         out_data  <= do_write ? {res_hi, res_lo} : '0;
      end
   end
endmodule

// File: rtl/lcu_chk.sv
module lcu_chk #(
   parameter int HALF_W = 64,
   parameter int IDX_W  = 5
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [1:0]          op_sel,
   input logic [2*HALF_W-1:0] src_a,
   input logic [2*HALF_W-1:0] src_b,
   input logic [IDX_W-1:0]    a_idx,
   input logic [IDX_W-1:0]    b_idx,
   input logic [IDX_W-1:0]    dst_idx,
   input logic                out_valid,
   input logic                out_wen,
   input logic [IDX_W-1:0]    out_dst,
   input logic [2*HALF_W-1:0] out_data
);
   localparam int REG_W = 2 * HALF_W;

   // R1
   reset_clears_chk: assert property (@(posedge clk) rst |=> (!out_valid && !out_wen));

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R2
   valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R2
   dst_echo_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_dst == $past(dst_idx)));

   // R8
   nowrite_dst0_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dst_idx == '0) |=> (!out_wen && out_data == '0));

   // R9
   reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b11) |=> !out_wen);

   // R4
   bcast_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b00 && b_idx == '0 && dst_idx != '0)
      |=> (out_wen && out_data == '0));

   // R5
   cpylo_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b01 && a_idx != '0 && dst_idx != '0)
      |=> (out_data[REG_W-1:HALF_W] == $past(src_a[HALF_W-1:0])));

   // R6
   cpyhi_lower_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b10 && a_idx != '0 && dst_idx != '0)
      |=> (out_data[HALF_W-1:0] == $past(src_a[REG_W-1:HALF_W])));

   // R2
   wen_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
      out_wen |-> out_valid);
endmodule

bind lane_copy_unit lcu_chk #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
   .src_a(src_a), .src_b(src_b), .a_idx(a_idx), .b_idx(b_idx),
   .dst_idx(dst_idx), .out_valid(out_valid), .out_wen(out_wen),
   .out_dst(out_dst), .out_data(out_data)
);

// File: tb/sim_lane_copy_unit.sv
module sim_lane_copy_unit;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [1:0]   op_sel;
   logic [127:0] src_a, src_b;
   logic [4:0]   a_idx, b_idx, dst_idx;
   logic         out_valid, out_wen;
   logic [4:0]   out_dst;
   logic [127:0] out_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_copy_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
      .src_a(src_a), .src_b(src_b), .a_idx(a_idx), .b_idx(b_idx),
      .dst_idx(dst_idx), .out_valid(out_valid), .out_wen(out_wen),
      .out_dst(out_dst), .out_data(out_data)
   );

   localparam logic [127:0] PAT_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
   localparam logic [127:0] PAT_B = 128'h1111_2222_3333_ABCD_5555_6666_7777_1234;

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Expected result built from the requirement text
   function automatic logic [127:0] model(logic [1:0] op, logic [127:0] a, logic [127:0] b,
                                          logic [4:0] ai, logic [4:0] bi, logic [4:0] di);
      logic [127:0] ga, gb;
      ga = (ai == 0) ? 128'h0 : a;
      gb = (bi == 0) ? 128'h0 : b;
      if (di == 0) return 128'h0;
      case (op)
         2'b00:   return {{4{gb[79:64]}}, {4{gb[15:0]}}};
         2'b01:   return {ga[63:0], gb[63:0]};
         2'b10:   return {gb[127:64], ga[127:64]};
         default: return 128'h0;
      endcase
   endfunction

   task automatic put(logic [1:0] op, logic [127:0] a, logic [127:0] b,
                      logic [4:0] ai, logic [4:0] bi, logic [4:0] di);
      in_valid = 1'b1; op_sel = op; src_a = a; src_b = b;
      a_idx = ai; b_idx = bi; dst_idx = di;
   endtask

   task automatic expect_out(string req, logic [1:0] op, logic [127:0] a, logic [127:0] b,
                             logic [4:0] ai, logic [4:0] bi, logic [4:0] di);
      logic ew;
      ew = (op != 2'b11) && (di != 0);
      check({req, " valid"}, {127'h0, out_valid}, 128'h1);
      check({req, " wen"},   {127'h0, out_wen},   {127'h0, ew});
      check({req, " dst"},   {123'h0, out_dst},   {123'h0, di});
      check({req, " data"},  out_data, model(op, a, b, ai, bi, di));
   endtask

   task automatic run_one(string req, logic [1:0] op, logic [127:0] a, logic [127:0] b,
                          logic [4:0] ai, logic [4:0] bi, logic [4:0] di);
      @(negedge clk);
      put(op, a, b, ai, bi, di);
      @(posedge clk); #1;
      in_valid = 1'b0;
      expect_out(req, op, a, b, ai, bi, di);
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1;
      put(2'b01, PAT_A, PAT_B, 5'd3, 5'd4, 5'd5);
      @(posedge clk); #1;
      in_valid = 1'b0;
      check("R1 valid", {127'h0, out_valid}, 128'h0);
      check("R1 wen",   {127'h0, out_wen},   128'h0);
      check("R1 dst",   {123'h0, out_dst},   128'h0);
      check("R1 data",  out_data,            128'h0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_bcast;
      run_one("R3 bcast", 2'b00, PAT_A, PAT_B, 5'd1, 5'd2, 5'd7);
      run_one("R3 bcast alt", 2'b00, PAT_B, PAT_A, 5'd9, 5'd31, 5'd31);
   endtask

   task automatic t_bcast_zero;
      run_one("R4 bcast zero src", 2'b00, PAT_A, PAT_B, 5'd1, 5'd0, 5'd6);
   endtask

   task automatic t_copy_lo;
      run_one("R5 copy lower", 2'b01, PAT_A, PAT_B, 5'd3, 5'd4, 5'd8);
   endtask

   task automatic t_copy_hi;
      run_one("R6 copy upper", 2'b10, PAT_A, PAT_B, 5'd3, 5'd4, 5'd8);
   endtask

   task automatic t_zero_src;
      run_one("R7 lower a0", 2'b01, PAT_A, PAT_B, 5'd0, 5'd4, 5'd2);
      run_one("R7 lower b0", 2'b01, PAT_A, PAT_B, 5'd3, 5'd0, 5'd2);
      run_one("R7 upper a0", 2'b10, PAT_A, PAT_B, 5'd0, 5'd4, 5'd2);
      run_one("R7 upper b0", 2'b10, PAT_A, PAT_B, 5'd3, 5'd0, 5'd2);
   endtask

   task automatic t_dst_zero;
      for (int m = 0; m < 3; m++)
         run_one("R8 dst zero", 2'(m), PAT_A, PAT_B, 5'd3, 5'd4, 5'd0);
   endtask

   task automatic t_bad_op;
      run_one("R9 reserved op", 2'b11, PAT_A, PAT_B, 5'd3, 5'd4, 5'd9);
   endtask

   task automatic t_stream;
      @(negedge clk);
      put(2'b01, PAT_A, PAT_B, 5'd1, 5'd2, 5'd10);
      @(posedge clk); #1;
      expect_out("R10 first", 2'b01, PAT_A, PAT_B, 5'd1, 5'd2, 5'd10);
      put(2'b10, PAT_B, PAT_A, 5'd1, 5'd2, 5'd11);
      @(posedge clk); #1;
      expect_out("R10 second", 2'b10, PAT_B, PAT_A, 5'd1, 5'd2, 5'd11);
      put(2'b00, ~PAT_A, PAT_B, 5'd1, 5'd2, 5'd12);
      @(posedge clk); #1;
      in_valid = 1'b0;
      expect_out("R10 third", 2'b00, ~PAT_A, PAT_B, 5'd1, 5'd2, 5'd12);
      @(posedge clk); #1;
      check("R2 valid drops", {127'h0, out_valid}, 128'h0);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; op_sel = 2'b00;
      src_a = '0; src_b = '0; a_idx = '0; b_idx = '0; dst_idx = '0;
      repeat (2) @(posedge clk);
      t_reset;
      t_bcast;
      t_bcast_zero;
      t_copy_lo;
      t_copy_hi;
      t_zero_src;
      t_dst_zero;
      t_bad_op;
      t_stream;
      done = 1;
      summary;
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary;
         $finish;
      end
   end
endmodule